// File: doc/BRIEF.md
# Shift-and-Add Three-Tap FIR Filter

This block filters a stream of signed 16-bit samples with the fixed difference equation y[n] = x[n] − 5·x[n−1] + 20·x[n−2]. It has no multiplier. Each constant product is built from operands shifted by wiring and then summed by adders. The ×5 result is reused to form the ×20 term. A sample is taken on any clock edge where the valid input is high. The matching filtered value appears on the output on the next cycle, qualified by an output valid flag.

Between the sample registers and the output register the arithmetic is purely combinational. The state the filter keeps is the previous sample and five times the sample before it. Because of this, a single ×5 adder serves both non-unit taps. Reset clears the history, so the first two outputs after reset are computed as if the earlier samples were zero. All sums wrap modulo 2^16.

Top module: `fir3_shiftadd`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid is 0 and out_data is 0.
- R2: For each accepted sample x[n], out_data equals x[n] − 5·x[n−1] + 20·x[n−2] taken modulo 2^16. Here x[n−1] and x[n−2] are the two previously accepted samples, and all values are 16-bit two's complement.
- R3: out_valid is 1 in exactly the cycle after an edge on which in_valid was 1. It is 0 in the cycle after an edge on which in_valid was 0.
- R4: An edge with in_valid low leaves the filter unchanged. out_data keeps its value, and the next accepted sample still uses the history from before the idle cycles.
- R5: After reset the history is zero. The first accepted sample x0 gives x0, and the second sample x1 gives x1 − 5·x0.
- R6: Signs are handled for negative and mixed-sign samples: the negative middle coefficient and the positive outer ones give the correct signed result for both signs of input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier; a sample is accepted when high |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | High for one cycle per accepted sample |
| out_data | output | 16 | Signed filtered result |

## Verification
On every cycle the assertions check several things. They check the one-cycle valid relationship and that the output holds across idle cycles. They also compare each result with a separately kept two-sample history that applies the equation with plain multiplication. The reset values, the zero history after a reset in mid-stream, and the fact that history survives gaps are shown by the bench's scenarios. The bench also covers the behaviour of specific negative sample patterns, checking each against hand-computed and model-computed values.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
    // default sample width
    localparam int SAMPLE_W = 16;
    // wired left shift used for the x4 partial product
    localparam int QUAD_SH = 2;
endpackage

// File: rtl/fir3_times5.sv
// Multiply by five as (a << 2) + a: one adder, shift is wiring only.
module fir3_times5 #(
    parameter int W  = fir3_pkg::SAMPLE_W,
    parameter int SH = fir3_pkg::QUAD_SH
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] p
);
    logic [W-1:0] a_sh;

    assign a_sh = {a[W-1-SH:0], {SH{1'b0}}};
    assign p    = a_sh + a;
endmodule

// File: rtl/fir3_sum.sv
// Final sum: x - (5*x1) + ((5*x2) << 2), modulo 2^W.
module fir3_sum #(
    parameter int W  = fir3_pkg::SAMPLE_W,
    parameter int SH = fir3_pkg::QUAD_SH
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] five_prev,
    input  logic [W-1:0] five_old,
    output logic [W-1:0] y
);
    logic [W-1:0] twenty_old;
    logic [W-1:0] diff;

    assign twenty_old = {five_old[W-1-SH:0], {SH{1'b0}}};
    assign diff       = cur - five_prev;
    assign y          = diff + twenty_old;
endmodule

// File: rtl/fir3_shiftadd.sv
module fir3_shiftadd #(
    parameter int DATA_W = fir3_pkg::SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int SH = fir3_pkg::QUAD_SH;

    typedef struct packed {
        logic [DATA_W-1:0] prev;     // x[n-1]
        logic [DATA_W-1:0] five_old; // 5*x[n-2], reused for the x20 tap
        logic [DATA_W-1:0] y;
        logic              vld;
    } fir_state_t;

    fir_state_t st_d, st_q;

    logic [DATA_W-1:0] five_prev;
    logic [DATA_W-1:0] y_c;

    fir3_times5 #(.W(DATA_W), .SH(SH)) u_x5 (
        .a (st_q.prev),
        .p (five_prev)
    );

    fir3_sum #(.W(DATA_W), .SH(SH)) u_sum (
        .cur       (in_data),
        .five_prev (five_prev),
        .five_old  (st_q.five_old),
        .y         (y_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.prev     = in_data;
            st_d.five_old = five_prev;
            st_d.y        = y_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.y;
endmodule

// File: rtl/fir3_shiftadd_chk.sv
module fir3_shiftadd_chk #(
    parameter int W = fir3_pkg::SAMPLE_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_data,
    input logic         out_valid,
    input logic [W-1:0] out_data
);
    logic [W-1:0] h1_q, h2_q;
    logic [W-1:0] expect_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1_q <= '0;
            h2_q <= '0;
        end else if (in_valid) begin
            h1_q <= in_data;
            h2_q <= h1_q;
        end
    end

    assign expect_c = W'(in_data - W'(5) * h1_q + W'(20) * h2_q);

    assert_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data == $past(expect_c)));

    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

bind fir3_shiftadd fir3_shiftadd_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/fir3_shiftadd_bench.sv
`timescale 1ns/100ps
module fir3_shiftadd_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic              out_valid;
    logic [15:0]       out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int h1 = 0, h2 = 0;

    localparam int NV = 8;
    localparam logic signed [15:0] STIM [NV] = '{16'sd1, 16'sd2, 16'sd3, -16'sd4,
                                                 16'sd10, 16'sd0, 16'sd100, -16'sd50};
    localparam logic signed [15:0] EXPV [NV] = '{16'sd1, -16'sd3, 16'sd13, 16'sd21,
                                                 16'sd90, -16'sd130, 16'sd300, -16'sd550};

    always #2.5 clk = ~clk;

    fir3_shiftadd u_fir3_shiftadd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(input int x0, input int x1, input int x2);
        return x0 - 5 * x1 + 20 * x2;
    endfunction

    // drive at a falling edge, results visible at the following falling edge
    task automatic push(input bit v, input int d);
        in_valid = v;
        in_data  = 16'(d);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push_check(input string req, input int d);
        int e;
        e = model(d, h1, h2);
        push(1'b1, d);
        h2 = h1;
        h1 = d;
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " data"}, int'($signed(out_data)), int'($signed(16'(e))));
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset data", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle valid", int'(out_valid), 0);
        chk("R1 first cycle data", int'(out_data), 0);

        // table walk: back-to-back samples, first two use zero history (R5)
        for (int i = 0; i < NV; i++) begin
            push(1'b1, int'(STIM[i]));
            chk(i < 2 ? "R5 table" : "R2 table", int'($signed(out_data)), int'(EXPV[i]));
            chk("R3 table valid", int'(out_valid), 1);
        end
        h1 = -50;
        h2 = 100;

        // idle cycles: no valid, output held, history kept
        for (int k = 0; k < 3; k++) begin
            push(1'b0, 16'sh1234);
            chk("R3 idle valid", int'(out_valid), 0);
            chk("R4 idle hold", int'($signed(out_data)), -550);
        end
        push_check("R4 history kept", 7);

        // sign handling
        push_check("R6 neg", -1000);
        push_check("R6 neg", -1000);
        push_check("R6 neg", -1000);
        push_check("R6 mixed", 300);
        push_check("R6 mixed", -600);
        push_check("R2 mixed", 25);

        // reset in mid-stream
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset valid", int'(out_valid), 0);
        chk("R1 mid reset data", int'(out_data), 0);
        rst_n = 1'b1;
        h1 = 0;
        h2 = 0;
        push_check("R5 after reset x0", 9);
        push_check("R5 after reset x1", -2);
        push_check("R2 after reset x2", 4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule